// File: doc/BRIEF.md
# Receive Self-Test Progress Tracker

This block follows a built-in self-test on the receive side of a 10-bit serial link. Once per decoded character it takes a strobe, the decoded byte, a control/data flag and a compare result from the local pattern generator. It then reports a 3-bit progress code. While self-test is enabled, that code takes the place of the normal receive status.

The block also watches two link-health inputs. Loss of receive PLL lock forces the tracker back to its start state at once. So does a slip of the elasticity buffer. After a slip the block holds the start state until a fixed number of characters has passed, which gives the buffer time to re-centre. The tracker then waits for the first character of a new test sequence before it compares again.

A running count of errors minus matches drops the tracker back to waiting when the link is too noisy. A pattern-restart output tells the generator to hold at the start of its sequence whenever no comparison is running.

Top module: `rx_selftest_tracker`

## Requirements
- R1: Status codes are 3'b000 idle/start, 3'b001 awaiting sequence start, 3'b010 compare good, 3'b011 compare error and 3'b100 loop complete. During reset the status is 3'b000. `restart_o` is 1 exactly when the status is 3'b000 or 3'b001.
- R2: With self-test enabled, a low `pll_lock_i` on any clock gives status 3'b000 after that edge, whatever the state.
- R3: A high `eb_slip_i` gives status 3'b000 after that edge and loads a blanking count of 9. Each character strobe while the count is nonzero lowers it by one.
- R4: The start state is left only on a clock where lock is high and the blanking count is zero. The next status is then 3'b001.
- R5: While awaiting sequence start, only a strobed data character (`chr_ctl_i`=0) with byte 8'h00 starts comparing. The status becomes 3'b010, and that character is pattern position 0. Control characters and other bytes leave the status at 3'b001.
- R6: In the compare states each strobed character is judged by `cmp_match_i`. A match gives 3'b010 and a mismatch gives 3'b011.
- R7: An error-minus-match count goes up on each mismatch and down on each match. It stops at zero and saturates at its top. It is cleared while the status is 3'b000 or 3'b001. The mismatch that takes the count to 17 gives status 3'b001.
- R8: Compared characters step a pattern position that wraps after `PAT_LEN` (default 16) characters. A match at the last position (15) gives 3'b100.
- R9: With `bist_en_i` low the status is 3'b000 on the next edge.
- R10: Clocks without a character strobe leave the status unchanged when no lock loss, slip or disable is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive character clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bist_en_i | input | 1 | Self-test compare mode enable |
| chr_vld_i | input | 1 | One decoded character present this clock |
| chr_byte_i | input | 8 | Decoded character value |
| chr_ctl_i | input | 1 | 1 = control character, 0 = data character |
| cmp_match_i | input | 1 | Character equals generator's expected value |
| pll_lock_i | input | 1 | Receive PLL locked |
| eb_slip_i | input | 1 | Elasticity buffer overflow/underflow |
| status_o | output | 3 | Self-test progress code |
| restart_o | output | 1 | Hold pattern generator at sequence start |

## Verification
The bench times the blanking window to the exact strobe. After eight strobes plus an idle clock the status must still be start, and it may move on only on the clock after the ninth strobe. A tracker that counts clocks instead of strobes, or that loads the wrong count, leaves too early.

It runs twenty matches before a burst of errors, so that the floor at zero is tested. A counter that went negative would need more than seventeen errors, and one that drops out at sixteen would leave the error burst early.

A control-coded 8'h00 and a nonzero data byte are sent while awaiting sequence start. A decoder that ignores the control flag would start comparing on the wrong character. The last-position match is checked for the loop-complete code both on the first pass and during the burst.

// File: rtl/rx_selftest_pkg.sv
package rx_selftest_pkg;
  typedef enum logic [2:0] {
    ST_START = 3'b000,
    ST_WAIT  = 3'b001,
    ST_GOOD  = 3'b010,
    ST_ERR   = 3'b011,
    ST_LOOP  = 3'b100
  } st_e;

  function automatic logic is_cmp(st_e s);
    return (s == ST_GOOD) || (s == ST_ERR) || (s == ST_LOOP);
  endfunction
endpackage

// File: rtl/rx_st_diff_cnt.sv
module rx_st_diff_cnt #(
  parameter int W      = 6,
  parameter int THRESH = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                step_i,
  input  logic                err_i,
  output logic                over_o,
  output logic signed [W-1:0] cnt_o
);
  localparam logic signed [W-1:0] MAX_S = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] THR_S = W'(THRESH);

  logic signed [W-1:0] cnt_q, cnt_d;

  // next mismatch would push the difference past the threshold
  assign over_o = step_i && err_i && (cnt_q >= THR_S);
  assign cnt_o  = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (step_i) begin
      if (err_i) begin
        if (cnt_q != MAX_S) cnt_d = cnt_q + W'(1);
      end else if (cnt_q != '0) begin
        cnt_d = cnt_q - W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  a_r7_never_negative: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q >= 0);
  a_r7_match_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !err_i && !clr_i && cnt_q == 0) |=> cnt_q == 0);
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == 0);
endmodule

// File: rtl/rx_st_blank_tmr.sv
module rx_st_blank_tmr #(
  parameter int CW    = 4,
  parameter int BLANK = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic load_i,
  input  logic tick_i,
  output logic zero_o
);
  localparam logic [CW-1:0] LOAD_V = CW'(BLANK);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (flush_i)                 cnt_q <= '0;
    else if (load_i)                  cnt_q <= LOAD_V;
    else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign zero_o = (cnt_q == '0);

  a_r3_load_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !flush_i) |=> cnt_q == LOAD_V);
  a_r3_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !flush_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rx_st_fsm.sv
module rx_st_fsm
  import rx_selftest_pkg::*;
#(
  parameter int PAT_LEN = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       vld_i,
  input  logic [7:0] byte_i,
  input  logic       ctl_i,
  input  logic       match_i,
  input  logic       lock_i,
  input  logic       slip_i,
  input  logic       blank_zero_i,
  input  logic       over_i,
  output logic       step_o,
  output logic       clr_o,
  output st_e        state_o
);
  localparam int PW = (PAT_LEN > 2) ? $clog2(PAT_LEN) : 1;
  localparam logic [PW-1:0] LAST_POS = PW'(PAT_LEN - 1);

  st_e           state_q, state_d;
  logic [PW-1:0] pos_q, pos_d;
  logic          force_start, seq_start, last;

  assign force_start = !en_i || !lock_i || slip_i;
  assign seq_start   = vld_i && !ctl_i && (byte_i == 8'h00);
  assign last        = (pos_q == LAST_POS);
  assign step_o      = !force_start && is_cmp(state_q) && vld_i;

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    if (force_start) begin
      state_d = ST_START;
    end else begin
      unique case (state_q)
        ST_START: if (blank_zero_i) state_d = ST_WAIT;
        ST_WAIT: begin
          if (seq_start) begin
            state_d = ST_GOOD;
            pos_d   = PW'(1);
          end
        end
        default: begin
          if (vld_i) begin
            pos_d = last ? '0 : pos_q + PW'(1);
            if (over_i)        state_d = ST_WAIT;
            else if (!match_i) state_d = ST_ERR;
            else if (last)     state_d = ST_LOOP;
            else               state_d = ST_GOOD;
          end
        end
      endcase
    end
  end

  assign clr_o = (state_d == ST_START) || (state_d == ST_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_START;
      pos_q   <= '0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
    end
  end

  assign state_o = state_q;

  a_r2_lock_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |=> state_q == ST_START);
  a_r9_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> state_q == ST_START);
  a_r4_exit_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && !blank_zero_i) |=> state_q == ST_START);
  a_r4_exit_to_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_START |=> (state_q == ST_START || state_q == ST_WAIT));
  a_r5_wait_filter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !force_start && (!vld_i || ctl_i || byte_i != 8'h00))
      |=> state_q == ST_WAIT);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vld_i && !force_start && state_q != ST_START) |=> $stable(state_q));
  a_r7_over_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && over_i) |=> state_q == ST_WAIT);
endmodule

// File: rtl/rx_selftest_tracker.sv
module rx_selftest_tracker
  import rx_selftest_pkg::*;
#(
  parameter int PAT_LEN = 16,
  parameter int DIFF_W  = 6,
  parameter int THRESH  = 16,
  parameter int BLANK   = 9,
  parameter int BLANK_W = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bist_en_i,
  input  logic       chr_vld_i,
  input  logic [7:0] chr_byte_i,
  input  logic       chr_ctl_i,
  input  logic       cmp_match_i,
  input  logic       pll_lock_i,
  input  logic       eb_slip_i,
  output logic [2:0] status_o,
  output logic       restart_o
);
  st_e                     state;
  logic                    step, clr, over, blank_zero;
  logic signed [DIFF_W-1:0] diff;

  rx_st_fsm #(.PAT_LEN(PAT_LEN)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (bist_en_i),
    .vld_i       (chr_vld_i),
    .byte_i      (chr_byte_i),
    .ctl_i       (chr_ctl_i),
    .match_i     (cmp_match_i),
    .lock_i      (pll_lock_i),
    .slip_i      (eb_slip_i),
    .blank_zero_i(blank_zero),
    .over_i      (over),
    .step_o      (step),
    .clr_o       (clr),
    .state_o     (state)
  );

  rx_st_diff_cnt #(.W(DIFF_W), .THRESH(THRESH)) u_diff (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr),
    .step_i(step),
    .err_i (!cmp_match_i),
    .over_o(over),
    .cnt_o (diff)
  );

  rx_st_blank_tmr #(.CW(BLANK_W), .BLANK(BLANK)) u_blank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(!bist_en_i),
    .load_i (eb_slip_i),
    .tick_i (chr_vld_i),
    .zero_o (blank_zero)
  );

  assign status_o  = state;
  assign restart_o = !is_cmp(state);

  a_r7_bounded_diff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_cmp(state) |-> diff <= DIFF_W'(THRESH));
  a_r1_code_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o <= 3'b100);
  a_r3_slip_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eb_slip_i |=> (status_o == 3'b000 && restart_o));
endmodule

// File: tb/sim_rx_selftest_tracker.sv
module sim_rx_selftest_tracker;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bist_en_i = 1'b0, chr_vld_i = 1'b0, chr_ctl_i = 1'b0;
  logic       cmp_match_i = 1'b0, pll_lock_i = 1'b0, eb_slip_i = 1'b0;
  logic [7:0] chr_byte_i = 8'hff;
  logic [2:0] status_o;
  logic       restart_o;

  typedef struct {
    logic [2:0] st;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_fail = 0;
  int   bpos = 0, bdiff = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_selftest_tracker u0 (
    .clk_i(clk), .rst_ni(rst_ni), .bist_en_i(bist_en_i), .chr_vld_i(chr_vld_i),
    .chr_byte_i(chr_byte_i), .chr_ctl_i(chr_ctl_i), .cmp_match_i(cmp_match_i),
    .pll_lock_i(pll_lock_i), .eb_slip_i(eb_slip_i),
    .status_o(status_o), .restart_o(restart_o)
  );

  task automatic check(logic [2:0] st, string tag);
    logic rs_exp;
    rs_exp = (st == 3'b000) || (st == 3'b001);
    n_chk++;
    if (status_o !== st || restart_o !== rs_exp) begin
      n_fail++;
      $display("FAIL %s: status=%b restart=%b expected status=%b restart=%b",
               tag, status_o, restart_o, st, rs_exp);
    end
  endtask

  // monitor: compare one queued item a little after every rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.st, e.tag);
      end
    end
  end

  task automatic drive(bit en, bit lock, bit slip, bit vld, bit ctl,
                       logic [7:0] b, bit m, logic [2:0] st, string tag);
    exp_t e;
    @(negedge clk);
    bist_en_i = en; pll_lock_i = lock; eb_slip_i = slip;
    chr_vld_i = vld; chr_ctl_i = ctl; chr_byte_i = b; cmp_match_i = m;
    e.st = st; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(logic [2:0] st, string tag);
    drive(1, 1, 0, 0, 0, 8'hff, 0, st, tag);
  endtask

  task automatic seq_start(string tag);
    drive(1, 1, 0, 1, 0, 8'h00, 1, 3'b010, tag);
    bpos = 1; bdiff = 0;
  endtask

  // compared character; expected code from R6/R7/R8
  task automatic cmp(bit m, string tag);
    logic [2:0] st;
    bit lastp;
    lastp = (bpos == 15);
    if (m) bdiff = (bdiff > 0) ? bdiff - 1 : 0;
    else   bdiff = bdiff + 1;
    if (bdiff >= 17)  begin st = 3'b001; bdiff = 0; end
    else if (!m)      st = 3'b011;
    else if (lastp)   st = 3'b100;
    else              st = 3'b010;
    bpos = lastp ? 0 : bpos + 1;
    drive(1, 1, 0, 1, 0, 8'h5a, m, st, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(3'b000, "R1 reset state");
    @(negedge clk);
    rst_ni = 1'b1;
    // R4: no lock, no exit
    drive(1, 0, 0, 0, 0, 8'hff, 0, 3'b000, "R4 no lock holds start");
    drive(1, 0, 0, 1, 0, 8'h00, 1, 3'b000, "R4 no lock holds start with char");
    idle(3'b001, "R4 exit to wait");
    // R5 filtering
    drive(1, 1, 0, 1, 1, 8'h00, 1, 3'b001, "R5 control 00 ignored");
    drive(1, 1, 0, 1, 0, 8'h05, 1, 3'b001, "R5 other data ignored");
    idle(3'b001, "R10 wait holds");
    seq_start("R5 sequence start");
    cmp(1, "R6 match");
    cmp(0, "R6 mismatch");
    idle(3'b011, "R10 error held without strobe");
    for (int i = 0; i < 12; i++) cmp(1, "R6 match run");
    cmp(1, "R8 loop complete");
    idle(3'b100, "R10 loop held");
    cmp(1, "R8 wrap to position 0");
    // R7 floor then threshold
    for (int i = 0; i < 20; i++) cmp(1, "R7 matches at floor");
    for (int i = 0; i < 16; i++) cmp(0, "R7 errors below threshold");
    cmp(0, "R7 threshold to wait");
    idle(3'b001, "R7 wait after threshold");
    seq_start("R5 restart after threshold");
    for (int i = 0; i < 16; i++) cmp(0, "R7 count cleared on wait");
    cmp(1, "R7 match lowers count");
    cmp(0, "R7 back to 16");
    cmp(0, "R7 threshold again");
    // R2 lock loss from compare
    seq_start("R5 start before lock loss");
    cmp(0, "R6 error before lock loss");
    drive(1, 0, 0, 0, 0, 8'hff, 0, 3'b000, "R2 lock loss");
    idle(3'b001, "R4 relock to wait");
    // R3 slip and blanking
    seq_start("R5 start before slip");
    drive(1, 1, 1, 0, 0, 8'hff, 0, 3'b000, "R3 slip to start");
    for (int i = 0; i < 8; i++) drive(1, 1, 0, 1, 0, 8'h00, 1, 3'b000, "R3 blanking");
    idle(3'b000, "R3 blanking not expired");
    drive(1, 1, 0, 1, 0, 8'h00, 1, 3'b000, "R3 ninth strobe");
    idle(3'b001, "R3 blanking expired");
    // R9 disable
    seq_start("R5 start before disable");
    drive(0, 1, 0, 1, 0, 8'h00, 1, 3'b000, "R9 disable");
    idle(3'b001, "R9 re-enable to wait");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule